// File: doc/BRIEF.md
# Backup Supply Switchover and Battery Health Controller

This block decides, cycle by cycle, whether a protected supply rail should be fed from the main supply or from a backup battery. It also runs a scheduled health check on that battery. It sees the analog world only through digital comparator flags: main supply below its reset threshold, main supply below the battery, main supply above the battery plus a small hysteresis margin, and battery below its test threshold. A rearm request puts the battery back into its shipping seal. The analog switches, the load resistor and the accuracy of the comparators belong to the surrounding circuitry.

A freshly reset controller is sealed. It will not connect the battery until main power has been seen good once, so a unit on the shelf does not drain its cell. After that, it moves to the battery only when the main supply has dropped below both the reset threshold and the battery. It returns to the main supply only once the main supply is clearly above the battery. Each time main power becomes good, the controller runs a battery test with the load connected. It then repeats the test after a fixed idle gap. The battery-OK flag holds the result of the last completed test, and it reads low while the rail runs from the battery.

Test length and idle gap are counted in clock cycles. Both are parameters, so short values can be used in simulation.

Top module: `bkup_supply_ctrl`

## Requirements
- R1: The controller enters battery mode (src_sel = 1, batt_on = 1, visible one clock after the sampling edge) only when the seal is released and main_below_rst and main_below_batt are both high at that edge. Each flag alone leaves it on the main supply (src_sel = 0).
- R2: In battery mode, the controller returns to the main supply one clock after an edge that samples main_above_hyst high. Main recovering above the reset threshold without main_above_hyst keeps it in battery mode.
- R3: batt_on is high exactly while src_sel selects the battery (1), and low while src_sel selects main (0).
- R4: After reset the controller is sealed, and battery mode is refused until an edge has sampled main_below_rst low. That edge releases the seal.
- R5: seal_rearm is accepted only at an edge where the seal is released and main_below_rst and main_below_batt are both high. Acceptance reseals the controller and, if it is in battery mode, drops back to the main supply at that edge. At any other time seal_rearm has no effect.
- R6: When main power becomes good (main_below_rst low and not in battery mode) after reset or after being absent, a test starts at that edge. load_en and test_act are then high for TEST_LEN cycles.
- R7: After a test ends, the next test starts after exactly TEST_GAP idle cycles, as long as main power stays good.
- R8: batt_ok is 0 after reset. It changes only at the last edge of a completed test, where it takes the inverse of batt_below_test. It holds between tests.
- R9: A running test is aborted without updating the stored result if main power stops being good. In battery mode no test runs and batt_ok reads 0. The stored result shows again once the rail is back on main.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_below_rst | input | 1 | Main supply is below the reset threshold |
| main_below_batt | input | 1 | Main supply is below the battery voltage |
| main_above_hyst | input | 1 | Main supply is above the battery voltage plus the return margin |
| batt_below_test | input | 1 | Battery reads below the health threshold |
| seal_rearm | input | 1 | Request to put the battery back into its shipping seal |
| src_sel | output | 1 | Rail source: 0 main, 1 battery |
| batt_on | output | 1 | High while the rail runs from the battery |
| batt_ok | output | 1 | Result of the last completed battery test, forced low in battery mode |
| load_en | output | 1 | Connects the test load during a battery test |
| test_act | output | 1 | High while a battery test is in progress |

## Verification
The assertions assume the comparator flags describe a physically consistent supply. main_above_hyst is never high together with main_below_batt, and it is never high while main_below_rst says the supply is collapsed together with the battery. The return check also assumes the flags are synchronous to the clock. The stimulus respects this: every table row and directed step raises main_above_hyst only with main_below_batt low. Flags change only on the falling clock edge, so each rising edge sees a settled, legal combination. The test schedule is driven with short parameter values, so full test and gap windows are counted exactly.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_BATT = 1'b1
  } src_e;

  typedef enum logic {
    TS_IDLE = 1'b0,
    TS_RUN  = 1'b1
  } tstate_e;
endpackage

// File: rtl/bkup_seal.sv
module bkup_seal (
  input  logic clk,
  input  logic rst,
  input  logic main_below_rst,
  input  logic main_below_batt,
  input  logic seal_rearm,
  output logic sealed,
  output logic rearm_hit
);
  // Rearm counts only while main has collapsed below both references.
  assign rearm_hit = !sealed && seal_rearm && main_below_rst && main_below_batt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sealed <= 1'b1;
    end else if (sealed && !main_below_rst) begin
      sealed <= 1'b0;
    end else if (rearm_hit) begin
      sealed <= 1'b1;
    end
  end

  // R4: the seal opens only after main power was seen good
  assert_seal_opens_on_main_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(sealed) |-> $past(!main_below_rst));

  // R5: resealing needs a request during a full collapse
  assert_reseal_needs_request_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sealed) |-> $past(seal_rearm && main_below_rst && main_below_batt));
endmodule

// File: rtl/bkup_switch.sv
module bkup_switch
  import bkup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic main_below_rst,
  input  logic main_below_batt,
  input  logic main_above_hyst,
  input  logic sealed,
  input  logic rearm_hit,
  output src_e mode_q
);
  src_e mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      SRC_MAIN: if (!sealed && !rearm_hit && main_below_rst && main_below_batt) mode_d = SRC_BATT;
      SRC_BATT: if (main_above_hyst || rearm_hit) mode_d = SRC_MAIN;
      default:  mode_d = SRC_MAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= SRC_MAIN;
    else     mode_q <= mode_d;
  end

  // R1: entry into battery mode needs both low-supply flags and an open seal
  assert_enter_two_cond_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q == SRC_BATT) |-> $past(main_below_rst && main_below_batt && !sealed));

  // R2: leaving battery mode needs the hysteresis flag or a rearm
  assert_exit_on_hyst_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_q == SRC_BATT) |-> $past(main_above_hyst || rearm_hit));
endmodule

// File: rtl/bkup_test_sched.sv
module bkup_test_sched
  import bkup_pkg::*;
#(
  parameter int unsigned TEST_LEN = 1235,
  parameter int unsigned TEST_GAP = 86400
) (
  input  logic clk,
  input  logic rst,
  input  logic main_below_rst,
  input  logic in_batt,
  input  logic batt_below_test,
  output logic running,
  output logic ok_q
);
  localparam int unsigned LW = (TEST_LEN < 2) ? 1 : $clog2(TEST_LEN);
  localparam int unsigned GW = (TEST_GAP < 2) ? 1 : $clog2(TEST_GAP);
  localparam logic [LW-1:0] LEN_LAST = LW'(TEST_LEN - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(TEST_GAP - 1);

  tstate_e        state_q;
  logic [LW-1:0]  len_cnt;
  logic [GW-1:0]  gap_cnt;
  logic           prev_good;
  logic           main_good;

  assign main_good = !main_below_rst && !in_batt;
  assign running   = (state_q == TS_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= TS_IDLE;
      len_cnt   <= '0;
      gap_cnt   <= '0;
      prev_good <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      prev_good <= main_good;
      unique case (state_q)
        TS_IDLE: begin
          if (main_good && (!prev_good || gap_cnt == GAP_LAST)) begin
            state_q <= TS_RUN;
            len_cnt <= '0;
            gap_cnt <= '0;
          end else if (main_good) begin
            gap_cnt <= gap_cnt + 1'b1;
          end else begin
            gap_cnt <= '0;
          end
        end
        TS_RUN: begin
          if (!main_good) begin
            state_q <= TS_IDLE;
            gap_cnt <= '0;
          end else if (len_cnt == LEN_LAST) begin
            state_q <= TS_IDLE;
            gap_cnt <= '0;
            ok_q    <= !batt_below_test;
          end else begin
            len_cnt <= len_cnt + 1'b1;
          end
        end
        default: state_q <= TS_IDLE;
      endcase
    end
  end

  // R8: the stored result moves only at the end of a running test
  assert_ok_only_at_end_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(ok_q) |-> $past(state_q == TS_RUN));

  // R6: the length counter never passes the last test cycle
  assert_len_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    running |-> (len_cnt <= LEN_LAST));

  // R9: a test never stays running once main power has gone
  assert_abort_on_loss_R9: assert property (@(posedge clk) disable iff (rst)
    $past(running && !main_good) |-> !running);
endmodule

// File: rtl/bkup_supply_ctrl.sv
module bkup_supply_ctrl
  import bkup_pkg::*;
#(
  parameter int unsigned TEST_LEN = 1235,
  parameter int unsigned TEST_GAP = 86400
) (
  input  logic clk,
  input  logic rst,
  input  logic main_below_rst,
  input  logic main_below_batt,
  input  logic main_above_hyst,
  input  logic batt_below_test,
  input  logic seal_rearm,
  output logic src_sel,
  output logic batt_on,
  output logic batt_ok,
  output logic load_en,
  output logic test_act
);
  logic sealed;
  logic rearm_hit;
  src_e mode_q;
  logic running;
  logic ok_q;

  bkup_seal u_seal (
    .clk             (clk),
    .rst             (rst),
    .main_below_rst  (main_below_rst),
    .main_below_batt (main_below_batt),
    .seal_rearm      (seal_rearm),
    .sealed          (sealed),
    .rearm_hit       (rearm_hit)
  );

  bkup_switch u_switch (
    .clk             (clk),
    .rst             (rst),
    .main_below_rst  (main_below_rst),
    .main_below_batt (main_below_batt),
    .main_above_hyst (main_above_hyst),
    .sealed          (sealed),
    .rearm_hit       (rearm_hit),
    .mode_q          (mode_q)
  );

  bkup_test_sched #(
    .TEST_LEN (TEST_LEN),
    .TEST_GAP (TEST_GAP)
  ) u_sched (
    .clk             (clk),
    .rst             (rst),
    .main_below_rst  (main_below_rst),
    .in_batt         (mode_q == SRC_BATT),
    .batt_below_test (batt_below_test),
    .running         (running),
    .ok_q            (ok_q)
  );

  assign src_sel  = mode_q;
  assign batt_on  = (mode_q == SRC_BATT);
  assign batt_ok  = ok_q && (mode_q != SRC_BATT);
  assign load_en  = running;
  assign test_act = running;

  // R4: a sealed controller never runs the rail from the battery
  assert_sealed_no_batt_R4: assert property (@(posedge clk) disable iff (rst)
    sealed |-> !batt_on);

  // R9: no test load while on the battery
  assert_no_test_in_backup_R9: assert property (@(posedge clk) disable iff (rst)
    batt_on |-> !load_en);
endmodule

// File: tb/test_bkup_supply_ctrl.sv
module test_bkup_supply_ctrl;
  localparam int unsigned LEN = 8;
  localparam int unsigned GAP = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br = 1'b0, bb = 1'b0, ah = 1'b1, bt = 1'b0, rm = 1'b0;
  logic src_sel, batt_on, batt_ok, load_en, test_act;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  bkup_supply_ctrl #(.TEST_LEN(LEN), .TEST_GAP(GAP)) i_bkup_supply_ctrl (
    .clk(clk), .rst(rst), .main_below_rst(br), .main_below_batt(bb),
    .main_above_hyst(ah), .batt_below_test(bt), .seal_rearm(rm),
    .src_sel(src_sel), .batt_on(batt_on), .batt_ok(batt_ok),
    .load_en(load_en), .test_act(test_act)
  );

  // Row fields: {br, bb, ah, rm, expected batt_on}
  localparam logic [4:0] VEC [17] = '{
    5'b1100_0, // sealed: refused (R4)
    5'b0010_0, // main good, seal released (R4)
    5'b1000_0, // below reset only (R1)
    5'b0100_0, // below battery only (R1)
    5'b1100_1, // both: enter battery (R1)
    5'b1000_1, // no hysteresis flag: stay (R2)
    5'b0000_1, // above reset, no hysteresis: stay (R2)
    5'b0010_0, // hysteresis: back to main (R2)
    5'b1100_1, // enter again (R1)
    5'b1101_0, // rearm accepted: main and resealed (R5)
    5'b1100_0, // sealed again (R5)
    5'b0010_0, // release
    5'b1100_1, // enter (R1)
    5'b0010_0, // back (R2)
    5'b0011_0, // rearm with main good is ignored (R5)
    5'b1100_1, // still released: enters (R5)
    5'b0010_0  // back (R2)
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Count consecutive samples with test_act at the given level.
  task automatic count_level(input logic lvl, output int n);
    n = 0;
    for (int k = 0; k < 1000 && test_act === lvl; k++) begin
      n++;
      step();
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    int n;
    // Reset state
    br = 1'b1; bb = 1'b1; ah = 1'b0;
    @(negedge clk);
    do_reset();
    check("R3 reset src_sel", src_sel, 1'b0);
    check("R3 reset batt_on", batt_on, 1'b0);
    check("R8 reset batt_ok", batt_ok, 1'b0);
    check("R6 reset load_en", load_en, 1'b0);
    check("R6 reset test_act", test_act, 1'b0);
    rst = 1'b0;

    // Table walk: switchover, return, seal and rearm
    for (int i = 0; i < 17; i++) begin
      {br, bb, ah, rm} = VEC[i][4:1];
      step();
      check($sformatf("R1/R2/R4/R5 row %0d batt_on", i), batt_on, VEC[i][0]);
      check($sformatf("R3 row %0d src_sel", i), src_sel, VEC[i][0]);
      if (VEC[i][0]) check($sformatf("R9 row %0d batt_ok", i), batt_ok, 1'b0);
    end
    rm = 1'b0;

    // Scheduler: reset with main good, test starts at first edge
    br = 1'b0; bb = 1'b0; ah = 1'b1; bt = 1'b0;
    do_reset();
    rst = 1'b0;
    step();
    check("R6 power-up test starts", test_act, 1'b1);
    check("R6 load_en with test", load_en, 1'b1);
    check("R8 batt_ok held during test", batt_ok, 1'b0);
    count_level(1'b1, n);
    check_int("R6 test length", n, LEN);
    check("R8 good battery gives ok", batt_ok, 1'b1);
    count_level(1'b0, n);
    check_int("R7 idle gap", n, GAP);

    // Second test with a weak battery
    bt = 1'b1;
    check("R8 ok held into next test", batt_ok, 1'b1);
    count_level(1'b1, n);
    check_int("R7 periodic test length", n, LEN);
    check("R8 weak battery clears ok", batt_ok, 1'b0);
    bt = 1'b0;
    count_level(1'b0, n);
    check_int("R7 second gap", n, GAP);

    // Third test aborted by loss of main power
    step();
    step();
    br = 1'b1;
    step();
    check("R9 abort drops test_act", test_act, 1'b0);
    check("R9 abort keeps result", batt_ok, 1'b0);
    step();
    check("R9 no test while main low", test_act, 1'b0);
    br = 1'b0;
    step();
    check("R6 restart when main returns", test_act, 1'b1);
    count_level(1'b1, n);
    check_int("R6 restarted test length", n, LEN);
    check("R8 restarted test sets ok", batt_ok, 1'b1);

    // Battery mode masks ok and suppresses tests
    br = 1'b1; bb = 1'b1; ah = 1'b0;
    step();
    check("R1 enter backup", batt_on, 1'b1);
    check("R9 ok low in backup", batt_ok, 1'b0);
    check("R9 no load in backup", load_en, 1'b0);
    br = 1'b0; bb = 1'b0;
    step();
    check("R2 no return without hysteresis", batt_on, 1'b1);
    check("R9 no test in backup with main up", test_act, 1'b0);
    ah = 1'b1;
    step();
    check("R2 return to main", batt_on, 1'b0);
    check("R9 stored ok shown again", batt_ok, 1'b1);
    step();
    check("R6 test after return to main", test_act, 1'b1);

    summary();
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule